// File: doc/BRIEF.md
# Bus Target Slave with Local Word Window

This block is the target side of a 32-bit PCI bus attachment. It watches the shared multiplexed address/data lines and claims memory read and memory write transactions whose address falls inside a small local window of word storage. Once claimed, it runs the data phases with the initiator and moves one 32-bit word on every edge where both sides are ready. A write honours the byte enables. A read always returns the whole word.

All bus control signals are active low. The block drives its three response signals (select, ready, halt) and the data lines through separate output-enable flags, so that the pads around it can tri-state them. Two local inputs let the back end refuse an access. One refusal makes the initiator try again later (a retry). The other reports a fatal error (a target abort). A burst that would run past the last word of the window is cut short by the target. The last valid word then carries a disconnect-with-data.

Top module: `pcit_target`

## Requirements
- R1: An access is claimed only when its address lies in [WIN_BASE, WIN_BASE + 4*WIN_WORDS) and its command on `lane_n` is 4'b0110 (memory read) or 4'b0111 (memory write). For any other access, `ctl_oe` and `mux_oe` stay low and `sel_n` stays high. The data lines are driven only while the select is low.
- R2: The address is captured on the edge where `cyc_n` is first seen low. For a claimed access, `sel_n` is still high at the next edge and is low at the second edge after the address edge (medium decode).
- R3: During the cycle after the address edge, `mux_oe` is low and `rdy_n` is high. On a read, data and ready appear together, at the earliest at the second edge.
- R4: A word moves only on an edge where `ini_rdy_n` and `rdy_n` are both low. Once `rdy_n` is low, it stays low and the read data stays unchanged until that handshake happens.
- R5: A write changes only the bytes whose enable bit `lane_n[b]` is 0. With `lane_n` = 4'b1111, storage is left as it was, but the word index still advances.
- R6: A read returns all 32 bits of the addressed word, whatever the byte enables are.
- R7: Within a burst, the word index starts at address bits [IDX_W+1:2] and rises by one for each transferred word.
- R8: When the word at index WIN_WORDS-1 is presented, `halt_n` is low together with `rdy_n` (disconnect with data). No word past the window end is transferred.
- R9: If that last word transfers while `cyc_n` is still low, the next cycle holds `halt_n` low with `rdy_n` high and `sel_n` low. This continues until `cyc_n` is seen high.
- R10: If `lcl_busy` is high at the address edge, the target answers with `sel_n` and `halt_n` low and `rdy_n` high (a retry). No word is transferred and storage is unchanged.
- R11: If `lcl_fault` is high at the address edge, `sel_n` goes low at the second edge. At the third edge, `sel_n` is high, `halt_n` is low and `rdy_n` is high (target abort). A request to abort begins only at the start of a data phase.
- R12: After the final edge (the initiator's framing is high and the phase completes), the target drives `sel_n`, `rdy_n` and `halt_n` high with `ctl_oe` high for one cycle. It then lowers `ctl_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_n | input | 1 | Initiator framing: low while the transaction continues |
| ini_rdy_n | input | 1 | Initiator ready, active low |
| mux_in | input | BUS_W | Multiplexed address/data lines as seen on the bus |
| lane_n | input | BUS_W/8 | Command during the address phase; active-low byte enables during data phases |
| lcl_busy | input | 1 | Back end asks for a retry of the access being decoded |
| lcl_fault | input | 1 | Back end asks for a target abort of the access being decoded |
| mux_out | output | BUS_W | Read data toward the bus |
| mux_oe | output | 1 | Drive enable for `mux_out` |
| sel_n | output | 1 | Target select response, active low |
| rdy_n | output | 1 | Target ready, active low |
| halt_n | output | 1 | Target stop request, active low |
| ctl_oe | output | 1 | Drive enable for `sel_n`, `rdy_n` and `halt_n` |

## Verification
The bench does writes from every starting word with three-word bursts. Near the window end, this sorts bursts into three kinds: those that finish on their own, those where the initiator's last word and the target's disconnect coincide, and those that must go through the extra stop-only phase. It sweeps all sixteen byte-enable patterns, each followed by a read-back, which separates merge errors per lane and the no-op all-high pattern. Read bursts with initiator wait states every third cycle show whether ready and data are held steady. Retry, abort, an out-of-window address and a non-memory command each check one termination or ignore path at the response pins. A following read then shows that storage was not touched.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

   // Command codes on the lane lines during the address phase
   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;

   typedef enum logic [2:0] {
      ST_IDLE,   // bus watched, nothing driven
      ST_DEC,    // cycle after address edge (turnaround)
      ST_DATA,   // selected, ready asserted
      ST_HOLD,   // selected, stop without ready
      ST_ABT1,   // selected, nothing else (abort pending)
      ST_ABT2,   // select released, stop asserted
      ST_FIN,    // all responses driven high for one cycle
      ST_IGN     // access belongs to someone else
   } pcit_st_e;

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
   import pcit_pkg::*;
#(
   parameter int          BUS_W    = 32,
   parameter int          IDX_W    = 4,
   parameter logic [31:0] WIN_BASE = 32'h0004_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_n,
   input  logic [BUS_W-1:0] mux_in,
   input  logic [3:0]       lane_n,
   output logic             start,
   output logic             claim,
   output logic             is_wr,
   output logic [IDX_W-1:0] idx0
);

   localparam int TAG_LO = IDX_W + 2;

   logic cyc_prev_n;
   logic in_win;
   logic is_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_prev_n <= 1'b1;
      else        cyc_prev_n <= cyc_n;
   end

   // framing only falls at the address phase
   assign start  = !cyc_n && cyc_prev_n;
   assign in_win = (mux_in[BUS_W-1:TAG_LO] == WIN_BASE[BUS_W-1:TAG_LO]);
   assign is_rd  = (lane_n == CMD_MEM_RD);
   assign is_wr  = (lane_n == CMD_MEM_WR);
   assign claim  = start && in_win && (is_rd || is_wr);
   assign idx0   = mux_in[TAG_LO-1:2];

endmodule

// File: rtl/pcit_regs.sv
module pcit_regs #(
   parameter int BUS_W = 32,
   parameter int WORDS = 16,
   parameter int IDX_W = 4
) (
   input  logic               clk,
   input  logic               we,
   input  logic [IDX_W-1:0]   idx,
   input  logic [BUS_W/8-1:0] lane_n,
   input  logic [BUS_W-1:0]   wdata,
   output logic [BUS_W-1:0]   rdata
);

   localparam int LANES = BUS_W / 8;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] lane_mem [WORDS];

      always_ff @(posedge clk) begin
         if (we && !lane_n[b]) lane_mem[idx] <= wdata[8*b +: 8];
      end

      assign rdata[8*b +: 8] = lane_mem[idx];
   end

endmodule

// File: rtl/pcit_ctrl.sv
module pcit_ctrl
   import pcit_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             claim,
   input  logic             is_wr,
   input  logic [IDX_W-1:0] idx0,
   input  logic             busy,
   input  logic             fault,
   input  logic             cyc_n,
   input  logic             ini_rdy_n,
   output logic [IDX_W-1:0] idx,
   output logic             we,
   output logic             mux_oe,
   output logic             sel_n,
   output logic             rdy_n,
   output logic             halt_n,
   output logic             ctl_oe
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   pcit_st_e st;
   logic     wr_q, busy_q, fault_q;
   logic     at_end;
   logic     xfer;

   assign at_end = (idx == LAST);
   assign xfer   = (st == ST_DATA) && !ini_rdy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         idx     <= '0;
         wr_q    <= 1'b0;
         busy_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               if (claim) begin
                  st      <= ST_DEC;
                  idx     <= idx0;
                  wr_q    <= is_wr;
                  busy_q  <= busy;
                  fault_q <= fault;
               end else begin
                  st <= ST_IGN;
               end
            end
            ST_DEC: begin
               if (fault_q)     st <= ST_ABT1;
               else if (busy_q) st <= ST_HOLD;
               else             st <= ST_DATA;
            end
            ST_DATA: if (xfer) begin
               idx <= idx + 1'b1;
               if (cyc_n)       st <= ST_FIN;
               else if (at_end) st <= ST_HOLD;
            end
            ST_HOLD: if (cyc_n) st <= ST_FIN;
            ST_ABT1: st <= ST_ABT2;
            ST_ABT2: if (cyc_n) st <= ST_FIN;
            ST_FIN:  st <= ST_IDLE;
            ST_IGN:  if (cyc_n && ini_rdy_n) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sel_n  = !(st inside {ST_DATA, ST_HOLD, ST_ABT1});
      rdy_n  = (st != ST_DATA);
      halt_n = !((st == ST_HOLD) || (st == ST_ABT2) ||
                 ((st == ST_DATA) && at_end));
      ctl_oe = (st inside {ST_DATA, ST_HOLD, ST_ABT1, ST_ABT2, ST_FIN});
      mux_oe = (st == ST_DATA) && !wr_q;
      we     = xfer && wr_q;
   end

endmodule

// File: rtl/pcit_target.sv
module pcit_target
   import pcit_pkg::*;
#(
   parameter int          BUS_W     = 32,
   parameter int          WIN_WORDS = 16,
   parameter logic [31:0] WIN_BASE  = 32'h0004_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_n,
   input  logic               ini_rdy_n,
   input  logic [BUS_W-1:0]   mux_in,
   input  logic [BUS_W/8-1:0] lane_n,
   input  logic               lcl_busy,
   input  logic               lcl_fault,
   output logic [BUS_W-1:0]   mux_out,
   output logic               mux_oe,
   output logic               sel_n,
   output logic               rdy_n,
   output logic               halt_n,
   output logic               ctl_oe
);

   localparam int IDX_W = $clog2(WIN_WORDS);

   initial begin
      assert (BUS_W == 32)
         else $error("pcit_target: only a 32-bit bus is supported");
      assert (WIN_WORDS >= 2 && (1 << IDX_W) == WIN_WORDS)
         else $error("pcit_target: WIN_WORDS must be a power of two >= 2");
      assert ((WIN_BASE & (32'(WIN_WORDS * 4) - 32'd1)) == 32'd0)
         else $error("pcit_target: WIN_BASE must be aligned to the window");
   end

   logic             start, claim, is_wr, we;
   logic [IDX_W-1:0] idx0, idx;

   pcit_decode #(.BUS_W(BUS_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc_n (cyc_n),
      .mux_in(mux_in),
      .lane_n(lane_n[3:0]),
      .start (start),
      .claim (claim),
      .is_wr (is_wr),
      .idx0  (idx0)
   );

   pcit_ctrl #(.WORDS(WIN_WORDS), .IDX_W(IDX_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .claim    (claim),
      .is_wr    (is_wr),
      .idx0     (idx0),
      .busy     (lcl_busy),
      .fault    (lcl_fault),
      .cyc_n    (cyc_n),
      .ini_rdy_n(ini_rdy_n),
      .idx      (idx),
      .we       (we),
      .mux_oe   (mux_oe),
      .sel_n    (sel_n),
      .rdy_n    (rdy_n),
      .halt_n   (halt_n),
      .ctl_oe   (ctl_oe)
   );

   pcit_regs #(.BUS_W(BUS_W), .WORDS(WIN_WORDS), .IDX_W(IDX_W)) u_regs (
      .clk   (clk),
      .we    (we),
      .idx   (idx),
      .lane_n(lane_n),
      .wdata (mux_in),
      .rdata (mux_out)
   );

   // ---------------- protocol checks ----------------
   logic claim_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) claim_d <= 1'b0;
      else        claim_d <= claim;
   end

   // R2
   claim_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> sel_n);
   // R2
   claim_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_d |=> !sel_n);
   // R3
   read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> (!mux_oe && rdy_n));
   // R4
   rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && ini_rdy_n) |=> (!rdy_n && $stable(mux_out)));
   // R9
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !halt_n && !ini_rdy_n && !cyc_n) |=> (rdy_n && !halt_n && !sel_n));
   // R11
   abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sel_n) && !halt_n) |-> ($past(rdy_n) && $past(halt_n)));
   // R12
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_oe) |-> ($past(sel_n) && $past(rdy_n) && $past(halt_n)));
   // R1
   data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mux_oe |-> (ctl_oe && !sel_n));

endmodule

// File: tb/pcit_target_bench.sv
module pcit_target_bench;

   localparam int          WORDS = 16;
   localparam logic [31:0] BASE  = 32'h0004_0000;
   localparam logic [3:0]  C_RD  = 4'b0110;
   localparam logic [3:0]  C_WR  = 4'b0111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_n = 1'b1, ini_rdy_n = 1'b1;
   logic [31:0] mux_in = '0;
   logic [3:0]  lane_n = 4'hF;
   logic        lcl_busy = 1'b0, lcl_fault = 1'b0;
   logic [31:0] mux_out;
   logic        mux_oe, sel_n, rdy_n, halt_n, ctl_oe;

   int errors = 0, checks = 0;
   bit done_flag = 0;
   logic [31:0] model [WORDS];

   always #2.5ns clk = ~clk;

   pcit_target #(.BUS_W(32), .WIN_WORDS(WORDS), .WIN_BASE(BASE)) u_pcit_target (
      .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .ini_rdy_n(ini_rdy_n),
      .mux_in(mux_in), .lane_n(lane_n), .lcl_busy(lcl_busy), .lcl_fault(lcl_fault),
      .mux_out(mux_out), .mux_oe(mux_oe), .sel_n(sel_n), .rdy_n(rdy_n),
      .halt_n(halt_n), .ctl_oe(ctl_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] pat(input int s, input int k, input int seed);
      return {8'(s), 8'(k), 16'(seed)} ^ 32'h5A3C_96E1;
   endfunction

   // Final cycle then release: R12
   task automatic finish_txn();
      check(ctl_oe && sel_n && rdy_n && halt_n && !mux_oe, "R12 final drive-high",
            {28'd0, ctl_oe, sel_n, rdy_n, halt_n}, 32'hF);
      cyc_n = 1'b1; ini_rdy_n = 1'b1;
      @(negedge clk);
      check(!ctl_oe && !mux_oe, "R12 release", {31'd0, ctl_oe}, 32'd0);
   endtask

   task automatic burst(input bit wr, input int s, input int n,
                        input logic [3:0] be, input int wt, input int seed);
      int done = 0, cyc = 0, ending = 0;
      int expn = (n < WORDS - s) ? n : WORDS - s;
      bit waited = 0;
      logic [31:0] held = '0;
      logic [31:0] d;
      @(negedge clk);
      cyc_n = 1'b0; ini_rdy_n = 1'b1; mux_in = BASE + 32'(s * 4); lane_n = wr ? C_WR : C_RD;
      @(negedge clk);
      check(!mux_oe && rdy_n && !ctl_oe, "R3 turnaround cycle",
            {29'd0, mux_oe, rdy_n, ctl_oe}, 32'h2);
      check(sel_n, "R2 no select at first edge", {31'd0, sel_n}, 32'd1);
      lane_n = be; mux_in = '0;
      @(negedge clk);
      check(!sel_n, "R2 medium select", {31'd0, sel_n}, 32'd0);
      while (ending == 0 && cyc < 200) begin
         bit irdy;
         if (waited) begin
            check(!rdy_n, "R4 ready held", {31'd0, rdy_n}, 32'd0);
            if (!wr) check(mux_out == held, "R4 data held", mux_out, held);
         end
         irdy = (wt > 0) && (cyc % wt == wt - 1);
         if (!irdy && done == n - 1) cyc_n = 1'b1;
         ini_rdy_n = irdy;
         d = pat(s, done, seed);
         if (wr) mux_in = d;
         waited = irdy && !rdy_n;
         held = mux_out;
         if (!irdy && !rdy_n) begin
            int ix = s + done;
            check(ix < WORDS, "R8 no word past window", 32'(ix), 32'(WORDS - 1));
            if (!wr) begin
               check(mux_oe && mux_out == model[ix % WORDS], "R6 read word R7",
                     mux_out, model[ix % WORDS]);
            end else begin
               for (int b = 0; b < 4; b++)
                  if (!be[b]) model[ix % WORDS][8*b +: 8] = d[8*b +: 8];
            end
            check(halt_n == !(ix == WORDS - 1), "R8 stop with last word",
                  {31'd0, halt_n}, {31'd0, !(ix == WORDS - 1)});
            done++;
            if (cyc_n) ending = 1;
            else if (!halt_n) ending = 2;
         end
         cyc++;
         @(negedge clk);
      end
      if (ending == 2) begin
         check(rdy_n && !halt_n && !sel_n, "R9 extra stop-only phase",
               {29'd0, rdy_n, halt_n, sel_n}, 32'h4);
         cyc_n = 1'b1; ini_rdy_n = 1'b0;
         @(negedge clk);
      end
      finish_txn();
      check(done == expn, "R7 R8 word count", 32'(done), 32'(expn));
   endtask

   task automatic retry_wr(input int ix);
      @(negedge clk);
      cyc_n = 1'b0; ini_rdy_n = 1'b1; mux_in = BASE + 32'(ix * 4); lane_n = C_WR;
      lcl_busy = 1'b1;
      @(negedge clk);
      lcl_busy = 1'b0; lane_n = 4'h0; mux_in = 32'hDEAD_BEEF; ini_rdy_n = 1'b0;
      @(negedge clk);
      check(!sel_n && !halt_n && rdy_n, "R10 retry response",
            {29'd0, sel_n, halt_n, rdy_n}, 32'h1);
      cyc_n = 1'b1;
      @(negedge clk);
      finish_txn();
   endtask

   task automatic abort_rd(input int ix);
      @(negedge clk);
      cyc_n = 1'b0; ini_rdy_n = 1'b1; mux_in = BASE + 32'(ix * 4); lane_n = C_RD;
      lcl_fault = 1'b1;
      @(negedge clk);
      lcl_fault = 1'b0; lane_n = 4'h0; ini_rdy_n = 1'b0;
      @(negedge clk);
      check(!sel_n && rdy_n && halt_n, "R11 select before abort",
            {29'd0, sel_n, rdy_n, halt_n}, 32'h3);
      @(negedge clk);
      check(sel_n && !halt_n && rdy_n && ctl_oe && !mux_oe, "R11 abort signalling",
            {27'd0, sel_n, halt_n, rdy_n, ctl_oe, mux_oe}, 32'h16);
      cyc_n = 1'b1;
      @(negedge clk);
      finish_txn();
   endtask

   task automatic foreign(input logic [31:0] addr, input logic [3:0] cmd);
      @(negedge clk);
      cyc_n = 1'b0; ini_rdy_n = 1'b1; mux_in = addr; lane_n = cmd;
      @(negedge clk);
      lane_n = 4'h0; mux_in = '0; ini_rdy_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(!ctl_oe && sel_n && !mux_oe, "R1 foreign access ignored",
               {29'd0, ctl_oe, sel_n, mux_oe}, 32'h2);
      end
      cyc_n = 1'b1;
      @(negedge clk);
      ini_rdy_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!ctl_oe && !mux_oe && sel_n && rdy_n && halt_n, "R12 reset state",
            {27'd0, ctl_oe, mux_oe, sel_n, rdy_n, halt_n}, 32'h7);
      rst_n = 1'b1;
      @(negedge clk);

      // fill window and probe the end: normal, coincident, disconnect-B
      for (int s = 0; s < WORDS; s++) burst(1'b1, s, 3, 4'h0, 0, 100 + s);
      for (int s = 0; s < WORDS; s++) burst(1'b0, s, 4, 4'hA, 3, 0);

      // byte-enable sweep with read-back (R5)
      for (int be = 0; be < 16; be++) begin
         burst(1'b1, be, 1, 4'(be), 0, 7000 + be);
         burst(1'b0, be, 1, 4'hF, 0, 0);
      end

      // retry: storage untouched (R10)
      retry_wr(2);
      burst(1'b0, 0, 4, 4'h0, 2, 0);

      // abort, then storage still intact (R11)
      abort_rd(5);
      burst(1'b0, 4, 3, 4'h0, 0, 0);

      // ignored accesses (R1)
      foreign(BASE + 32'(WORDS * 4), C_WR);
      foreign(BASE - 32'd4, C_RD);
      foreign(BASE + 32'd8, 4'b0011);
      burst(1'b0, 0, WORDS, 4'h0, 0, 0);
      burst(1'b0, 0, WORDS + 4, 4'h0, 4, 0);
      burst(1'b1, 6, WORDS, 4'h3, 5, 4242);
      burst(1'b0, 6, WORDS, 4'h0, 0, 0);

      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000ns;
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule